// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block supervises a processor's software by watching one service line that the program is expected to toggle. Every accepted transition of the line, rising or falling, restarts a timeout of `TIMEOUT_TICKS` clock cycles. If the timeout runs out, the block sends a one-cycle expiry request to the reset generator. If the line then stays stuck, it keeps sending one request per period, so a hung processor receives a train of reset requests rather than a single one.

The raw service line passes through a two-flop synchronizer. It then goes through a width filter, so a level must persist for `FILT_TICKS` cycles before it counts as a transition; for example, 7 cycles of 8 ns cover a 50 ns minimum service pulse. Two digital flags switch supervision off: one reports that the service line is floating or at mid-supply, the other reports battery-backup operation. While either flag is set, and while reset is asserted, the period counter is held at zero. When supervision resumes, a full period starts again. The default timeout of 200,000,000 cycles gives 1.6 s at 125 MHz. `rst_n` is asynchronous active-low and is expected to be deasserted in step with `clk`.

Top module: `svc_watchdog`

## Requirements
- R1: While `rst_n` is low, `expire_o` is 0. Reset counts as a restart, so the first expiry after release comes `TIMEOUT_TICKS` clock edges after the last edge at which reset was sampled low.
- R2: With supervision enabled and no accepted transition, `expire_o` is 1 after exactly the edges that lie `TIMEOUT_TICKS`, 2·`TIMEOUT_TICKS`, 3·`TIMEOUT_TICKS`, … clock edges after the last restart, and 0 after all other edges.
- R3: A low-to-high transition on `svc_line_i` that is held long enough is accepted and restarts the period.
- R4: A high-to-low transition on `svc_line_i` that is held long enough is accepted and restarts the period in the same way.
- R5: The restart caused by a transition takes place at the clock edge numbered `FILT_TICKS`+2, counting the first edge that samples the new level as edge 0. An expiry that would have fallen on that same edge is not issued.
- R6: A change on `svc_line_i` that reverts before `FILT_TICKS` edges have sampled it is ignored: the expiry schedule is unchanged.
- R7: While `line_float_i` is 1, every edge is a restart. The counter is held cleared and no expiry is issued. After the flag clears, a full period is counted before the next expiry.
- R8: While `backup_mode_i` is 1, the block behaves as described in R7.
- R9: Each expiry is exactly one cycle wide. Consecutive expiries on a stuck line, whether held high or low, are exactly `TIMEOUT_TICKS` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_line_i | input | 1 | Raw service line toggled by software |
| line_float_i | input | 1 | 1 = service line floating or at mid level; supervision off |
| backup_mode_i | input | 1 | 1 = system on battery backup; supervision off |
| expire_o | output | 1 | One-cycle reset request when the timeout runs out |

## Verification
The bench aims a transition so that its restart lands exactly on an edge where an expiry is due. A design that checks expiry before clearing would emit a stray reset there. It sends glitches one cycle shorter than the filter width; a design with an off-by-one filter would treat them as service and shift the schedule. It also holds the line stuck both high and low, and sets each disable flag for short and long stretches with transitions while disabled. Getting these wrong shows up as a missing periodic train, a second pulse or a pulse two cycles wide, or a shortened first period after re-enable.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Counter width able to hold values 0 .. n-1 (at least one bit).
  function automatic int cnt_width(int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdt_edge_filter.sv
module wdt_edge_filter #(
  parameter int FILT_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic edge_o
);
  localparam int DW = wdt_pkg::cnt_width(FILT_TICKS);
  localparam logic [DW-1:0] DC_LAST = DW'(FILT_TICKS - 1);

  logic          acc_q, acc_d;
  logic [DW-1:0] dc_q, dc_d;
  logic          edge_q, edge_d;
  logic          differ, hit;

  always_comb begin
    differ = lvl_i ^ acc_q;
    hit    = differ && (dc_q == DC_LAST);
    acc_d  = hit ? lvl_i : acc_q;
    if (!differ || hit) begin
      dc_d = '0;
    end else begin
      dc_d = dc_q + 1'b1;
    end
    edge_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      dc_q   <= '0;
      edge_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      dc_q   <= dc_d;
      edge_q <= edge_d;
    end
  end

  assign edge_o = edge_q;
endmodule

// File: rtl/wdt_period_ctr.sv
module wdt_period_ctr #(
  parameter int TIMEOUT_TICKS = 200_000_000,
  parameter int CW            = wdt_pkg::cnt_width(TIMEOUT_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          restart_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          at_end, clr;

  always_comb begin
    at_end = (cnt_q == CNT_LAST);
    clr    = !enable_i || restart_i || at_end;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
    exp_d  = enable_i && !restart_i && at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
  parameter int TIMEOUT_TICKS = 200_000_000,
  parameter int FILT_TICKS    = 7,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_line_i,
  input  logic line_float_i,
  input  logic backup_mode_i,
  output logic expire_o
);
  localparam int CW = wdt_pkg::cnt_width(TIMEOUT_TICKS);

  logic          svc_sync;
  logic          svc_edge;
  logic          sup_en;
  logic [CW-1:0] period_cnt;

  assign sup_en = !line_float_i && !backup_mode_i;

  wdt_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (svc_line_i),
    .q_o   (svc_sync)
  );

  wdt_edge_filter #(.FILT_TICKS(FILT_TICKS)) filt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (svc_sync),
    .edge_o (svc_edge)
  );

  wdt_period_ctr #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CW(CW)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable_i  (sup_en),
    .restart_i (svc_edge),
    .expire_o  (expire_o),
    .cnt_o     (period_cnt)
  );
endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int TIMEOUT_TICKS = 200_000_000,
  parameter int CW            = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_float_i,
  input logic          backup_mode_i,
  input logic          svc_edge,
  input logic          expire_o,
  input logic [CW-1:0] period_cnt
);
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o) else $error("expiry wider than one cycle"); // R9

  AST_FLOAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    line_float_i |=> (!expire_o && period_cnt == '0)) else $error("active while floating"); // R7

  AST_BACKUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    backup_mode_i |=> (!expire_o && period_cnt == '0)) else $error("active in backup"); // R8

  AST_SVC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    svc_edge |=> (period_cnt == '0)) else $error("service did not restart count"); // R3

  AST_SVC_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_edge |=> !expire_o) else $error("expiry on service edge"); // R5

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    period_cnt < CW'(TIMEOUT_TICKS)) else $error("count out of range"); // R2
endmodule

bind svc_watchdog svc_watchdog_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CW(CW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_float_i  (line_float_i),
  .backup_mode_i (backup_mode_i),
  .svc_edge      (svc_edge),
  .expire_o      (expire_o),
  .period_cnt    (period_cnt)
);

// File: tb/svc_watchdog_tb_top.sv
module svc_watchdog_tb_top;
  localparam int T = 40;
  localparam int F = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic svc = 1'b0;
  logic flt = 1'b0;
  logic bkp = 1'b0;
  logic expire;

  int    cyc = 0;
  int    last = 0;
  logic  exp_now = 1'b0;
  int    pend[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    timed_out = 1'b0;
  int unsigned seed_dummy;

  always #4 clk = ~clk;

  svc_watchdog #(.TIMEOUT_TICKS(T), .FILT_TICKS(F)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .svc_line_i    (svc),
    .line_float_i  (flt),
    .backup_mode_i (bkp),
    .expire_o      (expire)
  );

  // Expected expiry from the requirements: restart edges and period T.
  function automatic logic due(int c, int l);
    return ((c - l) > 0) && (((c - l) % T) == 0);
  endfunction

  always @(posedge clk) begin
    logic rs;
    cyc = cyc + 1;
    rs = !rst_n || flt || bkp;                       // R1 R7 R8
    if (pend.size() > 0 && pend[0] == cyc) begin     // R5 latency
      void'(pend.pop_front());
      rs = 1'b1;
    end
    exp_now = !rs && due(cyc, last);
    if (rs) last = cyc;
  end

  always @(negedge clk) begin
    if (!timed_out) begin
      n_cmp = n_cmp + 1;
      if (expire !== exp_now) begin
        n_bad = n_bad + 1;
        $display("FAIL %s cycle %0d expire=%0b expected=%0b", cur_req, cyc, expire, exp_now);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle();
    svc = ~svc;
    pend.push_back(cyc + 1 + F + 2);
  endtask

  task automatic glitch();
    svc = ~svc;
    repeat (F - 1) @(negedge clk);
    svc = ~svc;
  endtask

  task automatic run_all();
    int tgt;
    step(5);                              // R1: reset held
    rst_n = 1'b1;
    cur_req = "R2";
    step(3 * T + 2);
    cur_req = "R3";
    step(T / 2);
    toggle();                             // rising
    step(2 * T + 5);
    cur_req = "R4";
    toggle();                             // falling
    step(2 * T + 7);
    cur_req = "R5";
    tgt = last + T - F - 3;
    while (tgt <= cyc) tgt = tgt + T;
    while (cyc != tgt) @(negedge clk);
    toggle();                             // restart lands on a due edge
    step(2 * T + 3);
    cur_req = "R6";
    for (int i = 0; i < 6; i++) begin
      glitch();
      step(7);
    end
    step(2 * T);
    cur_req = "R7";
    flt = 1'b1;
    step(4);
    toggle();
    step(3 * T);
    flt = 1'b0;
    step(2 * T + 3);
    cur_req = "R8";
    bkp = 1'b1;
    step(2);
    bkp = 1'b0;
    step(T / 3);
    bkp = 1'b1;
    step(3 * T);
    bkp = 1'b0;
    step(2 * T + 1);
    cur_req = "R9";
    if (svc == 1'b0) toggle();            // stuck high
    step(3 * T + 4);
    toggle();                             // stuck low
    step(3 * T + 4);
    cur_req = "R1";
    rst_n = 1'b0;                         // reset mid-period
    step(3);
    rst_n = 1'b1;
    step(2 * T);
    cur_req = "R5";
    for (int i = 0; i < 220; i++) begin
      case ($urandom % 4)
        0: begin toggle(); step(F + 1 + int'($urandom % (2 * T))); end
        1: begin glitch(); step(1 + int'($urandom % T)); end
        2: begin
             if ($urandom % 2) flt = 1'b1; else bkp = 1'b1;
             step(1 + int'($urandom % 8));
             flt = 1'b0;
             bkp = 1'b0;
             step(F + 1);
           end
        default: step(T + int'($urandom % T));
      endcase
    end
    step(F + 4);
  endtask

  initial begin
    seed_dummy = $urandom(32'd20713);
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_cmp = n_cmp + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired in %s: actual=hung expected=done", cur_req);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule